// File: doc/BRIEF.md
# Nibble-Wide Program ROM Read Port

This block gives a 4-bit processor read access to a program ROM whose words are 12 bits wide. Software loads a ROM word address, four bits at a time, into three pointer registers. It then fetches the addressed word through three data addresses, one for each nibble. The pointer registers drive the ROM address pins continuously. The ROM is expected to return the word one clock after the address changes.

Each data-address read stalls the processor for one cycle through a wait output, so the read completes in two cycles. Pointer-register reads and unmapped reads complete at once. A write of the key value to the middle-nibble data address produces a single-cycle strobe that clears an external watchdog counter. Every other write to a data address is dropped.

Top module: `nrp_rom_port`

## Requirements
- R1: The pointer registers sit at bus addresses 18h (bits [3:0] of the ROM address), 19h (bits [7:4]) and 1Ah (bits [10:8]). A read of one of them returns, in the same cycle and without wait, exactly the 4 bits last written to it, including bit 3 of the 1Ah register.
- R2: `rom_addr` equals {ptr_1A[2:0], ptr_19, ptr_18} from the clock edge that completes a pointer write. Bit 3 of the 1Ah register never reaches `rom_addr`.
- R3: Reads of 1Ch, 1Dh and 1Eh return ROM word bits [3:0], [7:4] and [11:8] respectively. With pointers 1, 5, 6 and word 587h at address 156h, the three reads give 7h, 8h and 5h.
- R4: A data-address read holds `bus_wait` high for exactly its first cycle. In the second cycle `bus_wait` is low and `bus_rdata` carries the nibble.
- R5: A write of 5h to address 1Dh drives `wdt_clr` high for exactly the one clock cycle that follows the write edge.
- R6: A write of any value other than 5h to 1Dh, and any write to 1Ch or 1Eh, leaves `wdt_clr` low. Such writes change neither the pointers nor any data read.
- R7: An access to any address other than 18h–1Ah and 1Ch–1Eh reads as 0 without wait and changes no pointer.
- R8: A data read issued in the cycle right after a pointer write returns the nibble of the newly addressed word.
- R9: While reset is held and no access is made, `bus_wait`, `wdt_clr` and `bus_rdata` are all low.
- R10: `bus_wait` is asserted only during a read of a data address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address from the processor |
| bus_rd | input | 1 | Read request, held until `bus_wait` is low |
| bus_wr | input | 1 | Write request, one cycle per write |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, zero when no mapped read completes |
| bus_wait | output | 1 | Stall request toward the processor |
| rom_addr | output | 11 | Word address to the program ROM |
| rom_data | input | 12 | ROM word, valid one clock after `rom_addr` |
| wdt_clr | output | 1 | Single-cycle watchdog clear strobe |

## Verification
The bench builds the port with its default parameters: 4-bit nibbles, three pointers forming an 11-bit address, a 12-bit word, a 6-bit bus address and one wait cycle. This set places the all-ones address 7FFh and the unused fourth bit of the top pointer in the same 4-bit register, so both are exercised. It also makes the single wait cycle line up with a ROM model that registers its output once. A pointer write followed by a data read in the next cycle therefore tests that the address path adds no further delay.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

    localparam int unsigned NRP_NIB_W  = 4;
    localparam int unsigned NRP_NPTR   = 3;
    localparam int unsigned NRP_WORD_W = 12;
    localparam int unsigned NRP_ROM_AW = 11;
    localparam int unsigned NRP_BUS_AW = 6;
    localparam int unsigned NRP_WAIT   = 1;

    // class of the register addressed on the bus
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_PTR  = 2'd1,
        ACC_DATA = 2'd2
    } acc_e;

endpackage

// File: rtl/nrp_decode.sv
module nrp_decode
    import nrp_pkg::*;
#(
    parameter int unsigned          BUS_AW    = NRP_BUS_AW,
    parameter int unsigned          NPTR      = NRP_NPTR,
    parameter int unsigned          NNIB      = 3,
    parameter logic [BUS_AW-1:0]    PTR_BASE  = 6'h18,
    parameter logic [BUS_AW-1:0]    DATA_BASE = 6'h1C
) (
    input  logic [BUS_AW-1:0] addr,
    output acc_e              acc,
    output logic [NPTR-1:0]   ptr_sel,
    output logic [NNIB-1:0]   dat_sel
);

    always_comb begin
        for (int i = 0; i < int'(NPTR); i++) begin
            ptr_sel[i] = (addr == BUS_AW'(int'(PTR_BASE) + i));
        end
        for (int j = 0; j < int'(NNIB); j++) begin
            dat_sel[j] = (addr == BUS_AW'(int'(DATA_BASE) + j));
        end
        if (|ptr_sel) begin
            acc = ACC_PTR;
        end else if (|dat_sel) begin
            acc = ACC_DATA;
        end else begin
            acc = ACC_NONE;
        end
    end

endmodule

// File: rtl/nrp_ptr_bank.sv
module nrp_ptr_bank
    import nrp_pkg::*;
#(
    parameter int unsigned       NIB_W   = NRP_NIB_W,
    parameter int unsigned       NPTR    = NRP_NPTR,
    parameter int unsigned       ROM_AW  = NRP_ROM_AW,
    parameter logic [NIB_W-1:0]  PTR_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NPTR-1:0]   ptr_sel,
    input  logic [NIB_W-1:0]  wdata,
    output logic [NIB_W-1:0]  rd_nib,
    output logic [ROM_AW-1:0] rom_addr
);

    localparam int unsigned FLAT_W = NPTR * NIB_W;

    typedef struct packed {
        logic [NPTR-1:0][NIB_W-1:0] ptr;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [FLAT_W-1:0] flat;

    always_comb begin
        bank_d = bank_q;
        rd_nib = '0;
        for (int i = 0; i < int'(NPTR); i++) begin
            if (wr_en && ptr_sel[i]) begin
                bank_d.ptr[i] = wdata;
            end
            if (ptr_sel[i]) begin
                rd_nib = rd_nib | bank_q.ptr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '{ptr: {NPTR{PTR_RST}}};
        end else begin
            bank_q <= bank_d;
        end
    end

    // the pointers concatenate, lowest index in the lowest bits; upper
    // bits of the top pointer above ROM_AW are kept but not routed out
    assign flat     = bank_q.ptr;
    assign rom_addr = flat[ROM_AW-1:0];

endmodule

// File: rtl/nrp_read_seq.sv
module nrp_read_seq
    import nrp_pkg::*;
#(
    parameter int unsigned      NIB_W    = NRP_NIB_W,
    parameter int unsigned      NNIB     = 3,
    parameter int unsigned      WAIT_CYC = NRP_WAIT,
    parameter int unsigned      WDT_IDX  = 1,
    parameter logic [NIB_W-1:0] WDT_KEY  = 4'h5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [NIB_W-1:0] wdata,
    input  acc_e             acc,
    input  logic [NNIB-1:0]  dat_sel,
    output logic             bus_wait,
    output logic             data_ok,
    output logic             wdt_clr
);

    localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wdt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic data_rd;

    always_comb begin
        seq_d   = seq_q;
        data_rd = bus_rd && (acc == ACC_DATA);

        // wait-cycle counter: runs while a data read is held
        if (!data_rd || (seq_q.cnt == CNT_LAST)) begin
            seq_d.cnt = '0;
        end else begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end

        // watchdog key detection on the shared data address
        seq_d.wdt = bus_wr && dat_sel[WDT_IDX] && (wdata == WDT_KEY);

        bus_wait = data_rd && (seq_q.cnt != CNT_LAST);
        data_ok  = data_rd && (seq_q.cnt == CNT_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{cnt: '0, wdt: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wdt_clr = seq_q.wdt;

endmodule

// File: rtl/nrp_rom_port.sv
module nrp_rom_port
    import nrp_pkg::*;
#(
    parameter int unsigned       NIB_W     = NRP_NIB_W,
    parameter int unsigned       NPTR      = NRP_NPTR,
    parameter int unsigned       WORD_W    = NRP_WORD_W,
    parameter int unsigned       ROM_AW    = NRP_ROM_AW,
    parameter int unsigned       BUS_AW    = NRP_BUS_AW,
    parameter int unsigned       WAIT_CYC  = NRP_WAIT,
    parameter logic [BUS_AW-1:0] PTR_BASE  = 6'h18,
    parameter logic [BUS_AW-1:0] DATA_BASE = 6'h1C,
    parameter int unsigned       WDT_IDX   = 1,
    parameter logic [NIB_W-1:0]  WDT_KEY   = 4'h5,
    parameter logic [NIB_W-1:0]  PTR_RST   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [NIB_W-1:0]  bus_wdata,
    output logic [NIB_W-1:0]  bus_rdata,
    output logic              bus_wait,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    output logic              wdt_clr
);

    localparam int unsigned NNIB = WORD_W / NIB_W;

    acc_e                       acc;
    logic [NPTR-1:0]            ptr_sel;
    logic [NNIB-1:0]            dat_sel;
    logic [NIB_W-1:0]           ptr_nib;
    logic                       data_ok;
    logic [NNIB-1:0][NIB_W-1:0] nib_term;
    logic [NIB_W-1:0]           data_nib;

    nrp_decode #(
        .BUS_AW    (BUS_AW),
        .NPTR      (NPTR),
        .NNIB      (NNIB),
        .PTR_BASE  (PTR_BASE),
        .DATA_BASE (DATA_BASE)
    ) u_decode (
        .addr    (bus_addr),
        .acc     (acc),
        .ptr_sel (ptr_sel),
        .dat_sel (dat_sel)
    );

    nrp_ptr_bank #(
        .NIB_W   (NIB_W),
        .NPTR    (NPTR),
        .ROM_AW  (ROM_AW),
        .PTR_RST (PTR_RST)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .ptr_sel  (ptr_sel),
        .wdata    (bus_wdata),
        .rd_nib   (ptr_nib),
        .rom_addr (rom_addr)
    );

    nrp_read_seq #(
        .NIB_W    (NIB_W),
        .NNIB     (NNIB),
        .WAIT_CYC (WAIT_CYC),
        .WDT_IDX  (WDT_IDX),
        .WDT_KEY  (WDT_KEY)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .wdata    (bus_wdata),
        .acc      (acc),
        .dat_sel  (dat_sel),
        .bus_wait (bus_wait),
        .data_ok  (data_ok),
        .wdt_clr  (wdt_clr)
    );

    // one AND-gated slice per nibble of the ROM word
    for (genvar g = 0; g < int'(NNIB); g++) begin : g_nib
        assign nib_term[g] = dat_sel[g] ? rom_data[g*NIB_W +: NIB_W] : '0;
    end

    always_comb begin
        data_nib = '0;
        for (int k = 0; k < int'(NNIB); k++) begin
            data_nib = data_nib | nib_term[k];
        end
        bus_rdata = '0;
        if (bus_rd && (acc == ACC_PTR)) begin
            bus_rdata = ptr_nib;
        end else if (data_ok) begin
            bus_rdata = data_nib;
        end
    end

endmodule

// File: rtl/nrp_rom_port_chk.sv
module nrp_rom_port_chk #(
    parameter int unsigned       NIB_W     = 4,
    parameter int unsigned       NPTR      = 3,
    parameter int unsigned       WORD_W    = 12,
    parameter int unsigned       ROM_AW    = 11,
    parameter int unsigned       BUS_AW    = 6,
    parameter int unsigned       WAIT_CYC  = 1,
    parameter logic [BUS_AW-1:0] PTR_BASE  = 6'h18,
    parameter logic [BUS_AW-1:0] DATA_BASE = 6'h1C,
    parameter int unsigned       WDT_IDX   = 1,
    parameter logic [NIB_W-1:0]  WDT_KEY   = 4'h5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [NIB_W-1:0]  bus_wdata,
    input logic [NIB_W-1:0]  bus_rdata,
    input logic              bus_wait,
    input logic [ROM_AW-1:0] rom_addr,
    input logic [WORD_W-1:0] rom_data,
    input logic              wdt_clr
);

    localparam int unsigned NNIB    = WORD_W / NIB_W;
    localparam int unsigned HI_BITS = ROM_AW - (NPTR - 1) * NIB_W;
    localparam logic [BUS_AW-1:0] WDT_ADDR = BUS_AW'(int'(DATA_BASE) + int'(WDT_IDX));
    localparam logic [BUS_AW-1:0] HI_ADDR  = BUS_AW'(int'(PTR_BASE) + int'(NPTR) - 1);

    logic       in_ptr, in_dat, key_wr;
    logic [7:0] run_q;

    assign in_ptr = (bus_addr >= PTR_BASE) && (int'(bus_addr) < int'(PTR_BASE) + int'(NPTR));
    assign in_dat = (bus_addr >= DATA_BASE) && (int'(bus_addr) < int'(DATA_BASE) + int'(NNIB));
    assign key_wr = bus_wr && (bus_addr == WDT_ADDR) && (bus_wdata == WDT_KEY);

    // length of the current run of wait cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!bus_wait) begin
            run_q <= '0;
        end else if (run_q != 8'hFF) begin
            run_q <= run_q + 8'd1;
        end
    end

    a_r4_wait_len: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> (int'(run_q) < int'(WAIT_CYC)));

    a_r10_wait_only_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> (bus_rd && in_dat));

    a_r5_key_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> wdt_clr);

    a_r6_no_stray_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |-> $past(key_wr));

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_ptr && !in_dat) |-> (bus_rdata == '0 && !bus_wait));

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && in_ptr) |=> $stable(rom_addr));

    a_r2_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == HI_ADDR) |=>
            (rom_addr[ROM_AW-1 -: HI_BITS] == $past(bus_wdata[HI_BITS-1:0])));

    for (genvar g = 0; g < int'(NNIB); g++) begin : g_r3
        a_r3_nibble: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_wait && bus_addr == BUS_AW'(int'(DATA_BASE) + g)) |->
                (bus_rdata == rom_data[g*NIB_W +: NIB_W]));
    end

endmodule

bind nrp_rom_port nrp_rom_port_chk #(
    .NIB_W     (NIB_W),
    .NPTR      (NPTR),
    .WORD_W    (WORD_W),
    .ROM_AW    (ROM_AW),
    .BUS_AW    (BUS_AW),
    .WAIT_CYC  (WAIT_CYC),
    .PTR_BASE  (PTR_BASE),
    .DATA_BASE (DATA_BASE),
    .WDT_IDX   (WDT_IDX),
    .WDT_KEY   (WDT_KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_wait  (bus_wait),
    .rom_addr  (rom_addr),
    .rom_data  (rom_data),
    .wdt_clr   (wdt_clr)
);

// File: tb/nrp_rom_port_bench.sv
module nrp_rom_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [1:0] OP_W = 2'd0;   // pointer or data write
    localparam logic [1:0] OP_P = 2'd1;   // pointer read-back
    localparam logic [1:0] OP_D = 2'd2;   // data read

    typedef struct packed {
        logic [1:0] op;
        logic [5:0] addr;
        logic [3:0] val;
        logic [3:0] exp;
    } vec_t;

    function automatic logic [11:0] rom_word(input logic [10:0] a);
        if (a == 11'h156) return 12'h587;
        return 12'((int'(a) * 7 + 32'h3C1) ^ (int'(a) << 1));
    endfunction

    function automatic logic [3:0] nib(input logic [10:0] a, input int idx);
        logic [11:0] w;
        w = rom_word(a);
        return w[idx*4 +: 4];
    endfunction

    localparam int NVEC = 21;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{OP_W, 6'h1A, 4'h1, 4'h0},
        '{OP_W, 6'h19, 4'h5, 4'h0},
        '{OP_W, 6'h18, 4'h6, 4'h0},
        '{OP_P, 6'h18, 4'h0, 4'h6},            // R1
        '{OP_P, 6'h19, 4'h0, 4'h5},
        '{OP_P, 6'h1A, 4'h0, 4'h1},
        '{OP_D, 6'h1C, 4'h0, 4'h7},            // R3 worked example
        '{OP_D, 6'h1D, 4'h0, 4'h8},
        '{OP_D, 6'h1E, 4'h0, 4'h5},
        '{OP_W, 6'h1A, 4'h9, 4'h0},            // bit 3 of top pointer set
        '{OP_P, 6'h1A, 4'h0, 4'h9},            // R1 keeps bit 3
        '{OP_D, 6'h1E, 4'h0, 4'h5},            // R2 bit 3 ignored
        '{OP_W, 6'h18, 4'h7, 4'h0},
        '{OP_D, 6'h1C, 4'h0, nib(11'h157, 0)},
        '{OP_D, 6'h1E, 4'h0, nib(11'h157, 2)},
        '{OP_W, 6'h1A, 4'h7, 4'h0},
        '{OP_W, 6'h19, 4'hF, 4'h0},
        '{OP_W, 6'h18, 4'hF, 4'h0},
        '{OP_D, 6'h1D, 4'h0, nib(11'h7FF, 1)},
        '{OP_D, 6'h1C, 4'h0, nib(11'h7FF, 0)},
        '{OP_P, 6'h19, 4'h0, 4'hF}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [3:0]  bus_wdata;
    logic [3:0]  bus_rdata;
    logic        bus_wait;
    logic [10:0] rom_addr;
    logic [11:0] rom_data;
    logic        wdt_clr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural ROM with one register of read latency
    always_ff @(posedge clk) rom_data <= rom_word(rom_addr);

    nrp_rom_port u_nrp_rom_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_wait  (bus_wait),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .wdt_clr   (wdt_clr)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [3:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_ptr_read(input logic [5:0] a, input logic [3:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, 12'(bus_rdata), 12'(exp));
        check("R10 no wait on non-data read", 12'(bus_wait), 12'h0);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_data_read(input logic [5:0] a, input logic [3:0] exp, input string req);
        int n;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        n = 0;
        while (bus_wait && n < 8) begin
            n++;
            @(negedge clk);
            #1;
        end
        check("R4 wait cycles", 12'(n), 12'h1);
        check(req, 12'(bus_rdata), 12'(exp));
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R9 reset wait", 12'(bus_wait), 12'h0);
        check("R9 reset wdt_clr", 12'(wdt_clr), 12'h0);
        check("R9 reset rdata", 12'(bus_rdata), 12'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_W:    do_write(VEC[i].addr, VEC[i].val);
                OP_P:    do_ptr_read(VEC[i].addr, VEC[i].exp, "R1 pointer read-back");
                default: do_data_read(VEC[i].addr, VEC[i].exp, "R3 data nibble");
            endcase
        end
        #1;
        check("R2 rom_addr all ones", 12'(rom_addr), 12'h7FF);

        // R7: unmapped reads and writes
        do_ptr_read(6'h00, 4'h0, "R7 unmapped read 00h");
        do_ptr_read(6'h1B, 4'h0, "R7 unmapped read 1Bh");
        do_ptr_read(6'h1F, 4'h0, "R7 unmapped read 1Fh");
        do_ptr_read(6'h3F, 4'h0, "R7 unmapped read 3Fh");
        do_write(6'h1B, 4'h3);
        do_write(6'h17, 4'h0);
        do_ptr_read(6'h18, 4'hF, "R7 pointer kept after unmapped write");
        do_ptr_read(6'h1A, 4'h7, "R7 top pointer kept after unmapped write");

        // R5: key write gives one-cycle strobe
        do_write(6'h1D, 4'h5);
        #1;
        check("R5 wdt_clr after key", 12'(wdt_clr), 12'h1);
        @(negedge clk); #1;
        check("R5 wdt_clr one cycle only", 12'(wdt_clr), 12'h0);

        // R6: non-key and other data writes
        do_write(6'h1D, 4'h4);
        #1;
        check("R6 non-key 1Dh write", 12'(wdt_clr), 12'h0);
        do_write(6'h1C, 4'h5);
        #1;
        check("R6 key to 1Ch", 12'(wdt_clr), 12'h0);
        do_write(6'h1E, 4'h5);
        #1;
        check("R6 key to 1Eh", 12'(wdt_clr), 12'h0);
        do_data_read(6'h1D, nib(11'h7FF, 1), "R6 data unchanged after writes");
        do_ptr_read(6'h19, 4'hF, "R6 pointer unchanged after data writes");

        // R8: pointer write then data read in the very next cycle
        @(negedge clk);
        bus_addr = 6'h18; bus_wdata = 4'h0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h1C; bus_rd = 1'b1;
        #1;
        check("R8 wait on back-to-back read", 12'(bus_wait), 12'h1);
        @(negedge clk); #1;
        check("R8 new address on next read", 12'(bus_rdata), 12'(nib(11'h7F0, 0)));
        bus_rd = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule